// File: doc/BRIEF.md
# Two-Port Multiplexed Sample-ROM Read Sequencer

This block fetches single bytes from two external sample ROMs. Each ROM sits on a narrow bus that carries both address and data. The sequencer drives the address in two bytes, low byte first. A strobe pin tells the external latch which byte is on the bus. The sequencer then releases the bus and pulls an active-low output enable, so the ROM can drive one data byte back. The byte is sampled and returned to the requester with a one-cycle valid pulse.

The two ports run at different step rates from the same system clock. The slow port (A) steps once every 12 clocks. The fast port (B) steps once every 2 clocks. Every read takes six steps. Port A reads start only on the boundaries of a free-running frame of 72 clocks. Port B reads are locked to that frame and may start only on every second frame boundary. A requester pulses its request with an address. The request waits in a one-deep slot until its port can start. A newer request made before the start replaces the waiting one.

Top module: `mrs_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, both ports keep their bus driver off, their strobe low, their output enable high and their valid low.
- R2: A read goes through these steps in order. First the low address byte (address bits 7:0) is driven with the strobe low. Next the strobe goes high. Then the high byte (bits 15:8) is driven. Then the strobe goes low. Finally the output enable goes low in the same cycle as the bus driver turns off.
- R3: On port A, one step lasts 12 clocks. The strobe rises 12 clocks after the start, the strobe stays high for 24 clocks, the output enable falls 48 clocks after the start and it stays low for 24 clocks.
- R4: On port B, one step lasts 2 clocks. The strobe rises 2 clocks after the start, the strobe stays high for 4 clocks, the output enable falls 8 clocks after the start and it stays low for 4 clocks.
- R5: Read data is sampled from the port's bus input halfway through the sixth step. It is presented on the data output with valid high for exactly one cycle: 66 clocks after the start on port A and 11 clocks after the start on port B. Valid is only ever high while the output enable is low.
- R6: Port A reads start only on clock edges 72·k (k ≥ 1), counted from the first edge after reset is released. Back-to-back requests are served one frame apart.
- R7: Port B reads start only on edges 72 + 144·k, counted the same way. Two port B starts are therefore at least 144 clocks apart.
- R8: A request made while its port is busy or waiting is held until the next allowed start. If a second request arrives before the held one starts, it replaces the held one, and only one read takes place.
- R9: After the output enable falls, the bus driver stays off until the next read starts on that port.
- R10: The ports are independent. A port B read needs no port A request, and reads on both ports may overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Port A read request pulse |
| a_addr | input | 16 | Port A byte address, sampled with a_req |
| a_valid | output | 1 | Port A one-cycle data-valid pulse |
| a_data | output | 8 | Port A returned byte |
| a_bus_out | output | 8 | Port A shared-bus output value |
| a_bus_en | output | 1 | Port A shared-bus driver enable |
| a_bus_in | input | 8 | Port A shared-bus input value |
| a_stb | output | 1 | Port A address-half strobe |
| a_oe_n | output | 1 | Port A ROM output enable, active low |
| b_req | input | 1 | Port B read request pulse |
| b_addr | input | 16 | Port B byte address, sampled with b_req |
| b_valid | output | 1 | Port B one-cycle data-valid pulse |
| b_data | output | 8 | Port B returned byte |
| b_bus_out | output | 8 | Port B shared-bus output value |
| b_bus_en | output | 1 | Port B shared-bus driver enable |
| b_bus_in | input | 8 | Port B shared-bus input value |
| b_stb | output | 1 | Port B address-half strobe |
| b_oe_n | output | 1 | Port B ROM output enable, active low |

## Verification
The assertions assume two things. First, each request is a single-cycle pulse with its address valid in that cycle. Second, the bus input is driven by the ROM model only while that port's output enable is low and its driver is off. On that basis they check pin relations: the strobe only with the bus driven, the enable only with the bus released, and port B starts never closer than 144 clocks. The bench respects these assumptions. Its ROM model answers only during the output-enable window, returns zero at other times, and issues every request as a one-clock pulse at a falling clock edge. The replacement test places both competing requests well inside a busy period, so neither can meet a frame boundary.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int BUS_W = 8;
  localparam int STEPS = 6;

  // Step index inside one read; each value is one step period
  typedef enum logic [2:0] {
    ST_LO     = 3'd0,  // low address byte on bus, strobe low
    ST_STB    = 3'd1,  // strobe high, low byte captured externally
    ST_HI     = 3'd2,  // high address byte on bus
    ST_DROP   = 3'd3,  // strobe low, high byte captured externally
    ST_OE     = 3'd4,  // bus released, output enable low
    ST_SAMPLE = 3'd5   // wait for ROM, sample at mid-step
  } step_t;

endpackage

// File: rtl/mrs_timebase.sv
module mrs_timebase #(
  parameter int DIV     = 12,
  parameter int STEPS   = 6,
  parameter int B_EVERY = 2
) (
  input  logic clk,
  input  logic rst,
  output logic a_go,
  output logic b_go
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int ST_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int SL_W = (B_EVERY > 1) ? $clog2(B_EVERY) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STEPS - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(B_EVERY - 1);

  logic [PH_W-1:0] ph;
  logic [ST_W-1:0] st;
  logic [SL_W-1:0] slot;
  logic            frame_end;

  assign frame_end = (ph == PH_LAST) && (st == ST_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      st   <= '0;
      slot <= '0;
    end else if (ph == PH_LAST) begin
      ph <= '0;
      st <= (st == ST_LAST) ? '0 : st + 1'b1;
      if (frame_end) slot <= (slot == SL_LAST) ? '0 : slot + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign a_go = frame_end;
  assign b_go = frame_end && (slot == '0);

endmodule

// File: rtl/mrs_port.sv
module mrs_port
  import mrs_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              go,
  output logic              valid,
  output logic [BUS_W-1:0]  data,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_en,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              stb,
  output logic              oe_n
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(DIV / 2 - 1);

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [BUS_W-1:0]  cur_hi;
  logic              busy;
  step_t             step;
  logic [PH_W-1:0]   ph;
  logic              seq_done;
  logic              start;

  assign seq_done = busy && (ph == PH_LAST) && (step == ST_SAMPLE);
  assign start    = (!busy || seq_done) && go && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      cur_hi    <= '0;
      busy      <= 1'b0;
      step      <= ST_LO;
      ph        <= '0;
      valid     <= 1'b0;
      data      <= '0;
      bus_out   <= '0;
      bus_en    <= 1'b0;
      stb       <= 1'b0;
      oe_n      <= 1'b1;
    end else begin
      valid <= 1'b0;

      // one-deep waiting slot; a fresh request wins over consumption
      if (start) pend <= 1'b0;
      if (req) begin
        pend      <= 1'b1;
        pend_addr <= addr;
      end

      if (start) begin
        busy    <= 1'b1;
        step    <= ST_LO;
        ph      <= '0;
        cur_hi  <= pend_addr[ADDR_W-1:BUS_W];
        bus_out <= pend_addr[BUS_W-1:0];
        bus_en  <= 1'b1;
        stb     <= 1'b0;
        oe_n    <= 1'b1;
      end else if (seq_done) begin
        busy <= 1'b0;
        oe_n <= 1'b1;
      end else if (busy) begin
        if (ph == PH_LAST) begin
          ph   <= '0;
          step <= step_t'(step + 3'd1);
          case (step)
            ST_LO:   stb     <= 1'b1;
            ST_STB:  bus_out <= cur_hi;
            ST_HI:   stb     <= 1'b0;
            ST_DROP: begin
              oe_n   <= 1'b0;
              bus_en <= 1'b0;
            end
            default: ;
          endcase
        end else begin
          ph <= ph + 1'b1;
          if (ph == PH_FALL && step == ST_SAMPLE) begin
            valid <= 1'b1;
            data  <= bus_in;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_pkg::*;
#(
  parameter int BUS_W   = mrs_pkg::BUS_W,
  parameter int A_DIV   = 12,
  parameter int B_DIV   = 2,
  parameter int B_EVERY = 2,
  parameter int ADDR_W  = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic [ADDR_W-1:0] a_addr,
  output logic              a_valid,
  output logic [BUS_W-1:0]  a_data,
  output logic [BUS_W-1:0]  a_bus_out,
  output logic              a_bus_en,
  input  logic [BUS_W-1:0]  a_bus_in,
  output logic              a_stb,
  output logic              a_oe_n,
  input  logic              b_req,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              b_valid,
  output logic [BUS_W-1:0]  b_data,
  output logic [BUS_W-1:0]  b_bus_out,
  output logic              b_bus_en,
  input  logic [BUS_W-1:0]  b_bus_in,
  output logic              b_stb,
  output logic              b_oe_n
);
  logic a_go;
  logic b_go;

  mrs_timebase #(
    .DIV     (A_DIV),
    .STEPS   (STEPS),
    .B_EVERY (B_EVERY)
  ) u_tb (
    .clk  (clk),
    .rst  (rst),
    .a_go (a_go),
    .b_go (b_go)
  );

  mrs_port #(
    .DIV    (A_DIV),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
  ) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .req     (a_req),
    .addr    (a_addr),
    .go      (a_go),
    .valid   (a_valid),
    .data    (a_data),
    .bus_out (a_bus_out),
    .bus_en  (a_bus_en),
    .bus_in  (a_bus_in),
    .stb     (a_stb),
    .oe_n    (a_oe_n)
  );

  mrs_port #(
    .DIV    (B_DIV),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
  ) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .req     (b_req),
    .addr    (b_addr),
    .go      (b_go),
    .valid   (b_valid),
    .data    (b_data),
    .bus_out (b_bus_out),
    .bus_en  (b_bus_en),
    .bus_in  (b_bus_in),
    .stb     (b_stb),
    .oe_n    (b_oe_n)
  );

endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk #(
  parameter int B_GAP = 144
) (
  input logic clk,
  input logic rst,
  input logic a_valid,
  input logic a_bus_en,
  input logic a_stb,
  input logic a_oe_n,
  input logic b_valid,
  input logic b_bus_en,
  input logic b_stb,
  input logic b_oe_n
);
  logic        b_en_q;
  logic [15:0] b_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_en_q <= 1'b0;
      b_gap  <= '1;
    end else begin
      b_en_q <= b_bus_en;
      if (b_bus_en && !b_en_q) b_gap <= 16'd1;
      else if (b_gap != '1)    b_gap <= b_gap + 16'd1;
    end
  end

  // R2
  a_stb_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    a_stb |-> a_bus_en);
  // R2
  b_stb_needs_bus_chk: assert property (@(posedge clk) disable iff (rst)
    b_stb |-> b_bus_en);
  // R2
  a_oe_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    !a_oe_n |-> !a_bus_en);
  // R2
  b_oe_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    !b_oe_n |-> !b_bus_en);
  // R5
  a_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    a_valid |=> !a_valid);
  // R5
  b_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    b_valid |=> !b_valid);
  // R5
  a_valid_in_oe_chk: assert property (@(posedge clk) disable iff (rst)
    a_valid |-> !a_oe_n);
  // R5
  b_valid_in_oe_chk: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> !b_oe_n);
  // R9
  a_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(a_bus_en) |-> !a_oe_n);
  // R9
  b_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(b_bus_en) |-> !b_oe_n);
  // R7
  b_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (b_bus_en && !b_en_q) |-> (b_gap >= 16'(B_GAP)));

endmodule

bind mrs_seq mrs_seq_chk u_chk (.*);

// File: tb/mrs_seq_test.sv
module mrs_seq_test;
  localparam int CLK_PERIOD = 125;
  localparam int A_DIV = 12;
  localparam int B_DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_req = 1'b0, b_req = 1'b0;
  logic [15:0] a_addr = '0, b_addr = '0;
  logic        a_valid, b_valid, a_bus_en, b_bus_en, a_stb, b_stb, a_oe_n, b_oe_n;
  logic [7:0]  a_data, b_data, a_bus_out, b_bus_out, a_bus_in, b_bus_in;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mrs_seq uut (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_addr(a_addr), .a_valid(a_valid), .a_data(a_data),
    .a_bus_out(a_bus_out), .a_bus_en(a_bus_en), .a_bus_in(a_bus_in),
    .a_stb(a_stb), .a_oe_n(a_oe_n),
    .b_req(b_req), .b_addr(b_addr), .b_valid(b_valid), .b_data(b_data),
    .b_bus_out(b_bus_out), .b_bus_en(b_bus_en), .b_bus_in(b_bus_in),
    .b_stb(b_stb), .b_oe_n(b_oe_n)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] rom(input int p, input logic [15:0] ad);
    return ad[7:0] ^ {ad[11:8], ad[15:12]} ^ ((p == 0) ? 8'h3C : 8'hC3);
  endfunction

  // per-port views of the pins
  logic       en[2], sb[2], oe[2], vl[2];
  logic [7:0] bo[2], dt[2];
  logic [7:0] bin[2] = '{8'h00, 8'h00};
  assign en[0] = a_bus_en;  assign en[1] = b_bus_en;
  assign sb[0] = a_stb;     assign sb[1] = b_stb;
  assign oe[0] = a_oe_n;    assign oe[1] = b_oe_n;
  assign vl[0] = a_valid;   assign vl[1] = b_valid;
  assign bo[0] = a_bus_out; assign bo[1] = b_bus_out;
  assign dt[0] = a_data;    assign dt[1] = b_data;
  assign a_bus_in = bin[0];
  assign b_bus_in = bin[1];

  // scoreboard queues of expected addresses
  logic [15:0] qa[$];
  logic [15:0] qb[$];

  int          starts[2] = '{0, 0};
  int          t_st[2], t_sr[2], t_of[2];
  int          last_b = -1;
  logic        en_q[2] = '{1'b0, 1'b0};
  logic        sb_q[2] = '{1'b0, 1'b0};
  logic        oe_q[2] = '{1'b1, 1'b1};
  logic [15:0] lat[2];

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < 2; p++) begin
        int          dv;
        logic [15:0] ex;
        bit          have;
        dv = (p == 0) ? A_DIV : B_DIV;
        if (en[p] && !en_q[p]) begin
          t_st[p] = cyc;
          starts[p]++;
          if (p == 0) chk(cyc % 72 == 0, "R6", cyc % 72, 0);
          else begin
            chk(cyc % 144 == 72, "R7", cyc % 144, 72);
            if (last_b >= 0) chk(cyc - last_b >= 144, "R7", cyc - last_b, 144);
            last_b = cyc;
          end
        end
        if (sb[p] && !sb_q[p]) begin
          lat[p][7:0] = bo[p];
          t_sr[p] = cyc;
          chk(cyc - t_st[p] == dv, (p == 0) ? "R3" : "R4", cyc - t_st[p], dv);
        end
        if (!sb[p] && sb_q[p]) begin
          lat[p][15:8] = bo[p];
          chk(cyc - t_sr[p] == 2 * dv, (p == 0) ? "R3" : "R4", cyc - t_sr[p], 2 * dv);
        end
        if (!oe[p] && oe_q[p]) begin
          t_of[p] = cyc;
          chk(!en[p], "R2", int'(en[p]), 0);
          chk(cyc - t_st[p] == 4 * dv, (p == 0) ? "R3" : "R4", cyc - t_st[p], 4 * dv);
          have = (p == 0) ? (qa.size() > 0) : (qb.size() > 0);
          ex = have ? ((p == 0) ? qa[0] : qb[0]) : 16'hFFFF;
          chk(have && lat[p] == ex, "R2", int'(lat[p]), int'(ex));
          bin[p] = rom(p, lat[p]);
        end
        if (oe[p] && !oe_q[p]) begin
          bin[p] = 8'h00;
          chk(cyc - t_of[p] == 2 * dv, (p == 0) ? "R3" : "R4", cyc - t_of[p], 2 * dv);
          chk(!en[p] || (t_st[p] == cyc), "R9", int'(en[p]), 0);
        end
        if (vl[p]) begin
          have = (p == 0) ? (qa.size() > 0) : (qb.size() > 0);
          if (!have) chk(1'b0, "R8", 1, 0);
          else begin
            ex = (p == 0) ? qa.pop_front() : qb.pop_front();
            chk(dt[p] == rom(p, ex), "R5", int'(dt[p]), int'(rom(p, ex)));
            chk(cyc - t_st[p] == 5 * dv + dv / 2, "R5", cyc - t_st[p], 5 * dv + dv / 2);
          end
        end
        en_q[p] = en[p];
        sb_q[p] = sb[p];
        oe_q[p] = oe[p];
      end
    end
  end

  // driver
  task automatic issue(input int p, input logic [15:0] ad, input bit keep);
    @(negedge clk);
    if (p == 0) begin a_req = 1'b1; a_addr = ad; end
    else        begin b_req = 1'b1; b_addr = ad; end
    if (keep) begin
      if (p == 0) qa.push_back(ad);
      else        qb.push_back(ad);
    end
    @(negedge clk);
    if (p == 0) a_req = 1'b0;
    else        b_req = 1'b0;
  endtask

  task automatic rd(input int p, input logic [15:0] ad);
    int n0;
    n0 = starts[p];
    issue(p, ad, 1'b1);
    while (starts[p] <= n0) @(negedge clk);
  endtask

  task automatic drain();
    while (qa.size() > 0 || qb.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle pins under reset
    chk(!a_bus_en && !b_bus_en && !a_stb && !b_stb, "R1", 1, 0);
    chk(a_oe_n && b_oe_n && !a_valid && !b_valid, "R1", 0, 1);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    // R1: no request, no activity
    chk(!a_bus_en && !b_bus_en && a_oe_n && b_oe_n, "R1", 0, 1);

    // single reads on each port (R2..R5, R10)
    rd(0, 16'h1234);
    rd(1, 16'hBEEF);
    drain();

    // back-to-back port A: each next request waits while busy (R6, R8)
    for (int i = 0; i < 3; i++) rd(0, 16'h0A00 + 16'(i * 37));
    drain();

    // back-to-back port B: paced to every second frame (R7)
    for (int i = 0; i < 3; i++) rd(1, 16'h5500 + 16'(i * 91));
    drain();

    // overlapping reads on both ports (R10)
    fork
      rd(0, 16'hC0DE);
      rd(1, 16'h0F0F);
    join
    drain();

    // replacement of a waiting request (R8)
    rd(0, 16'h2222);
    repeat (5) @(negedge clk);
    issue(0, 16'h3333, 1'b0);
    repeat (5) @(negedge clk);
    issue(0, 16'h4444, 1'b1);
    drain();
    repeat (200) @(negedge clk);
    chk(qa.size() == 0 && qb.size() == 0, "R8", qa.size() + qb.size(), 0);

    // R9: buses stay released while idle
    chk(!a_bus_en && !b_bus_en, "R9", int'(a_bus_en) + int'(b_bus_en), 0);
    chk(a_oe_n && b_oe_n, "R9", 0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule